// File: doc/BRIEF.md
# GPIO Port Controller with Per-Pin Interrupt Triggers

This block controls a single general-purpose I/O port of up to eight pins. It sits behind a simple memory-mapped register bus. Each pin has a private 32-byte register window. In that window the pin can be enabled, switched between input and output, given an output level and a float control, given a debounce threshold, and set up to raise an interrupt.

Pad inputs pass through a two-flop synchronizer and then an optional debounce filter. The filtered level can be read back, and it feeds trigger detection. Each pin can flag an interrupt on:
- a high or a low level,
- a rising or a falling edge,
- either edge.

A detected trigger sets a sticky pending bit. Software clears that bit by writing to the pin's clear register. The pending bits of all pins can be read together at a port-level status address. The pending bits whose interrupt enable is set are ORed onto a single interrupt line.

Each pad is driven in tristate style: an output value and an output enable.

Top module: `gpio_irq_port`

## Requirements
- R1: Pin n owns byte addresses n*0x20 to n*0x20+0x1F. Inside a window the registers are: configuration at 0x00, debounce threshold at 0x04, input level at 0x08, float control at 0x0C, output value at 0x10 and pending clear at 0x14. Address 0x104 returns the pending bits, with bit n for pin n. Any other address reads 0, and writes to it change nothing.
- R2: The configuration register has these fields:
  - bit 0: pin enable
  - bit 1: direction (1 = output)
  - bits [3:2]: trigger type (0 none, 1 level, 2 single edge, 3 both edges)
  - bit 4: polarity
  - bit 6: interrupt enable

  Bits 5 and 7 always read 0.
- R3: Bit 0 of offset 0x08 returns the pad level after two synchronizer flops. With a threshold of 0, a pad change becomes readable after the second rising clock edge. Writes to 0x08 have no effect.
- R4: With a threshold T greater than 0, a new synchronized level is accepted only after it has stayed unchanged for T+1 cycles. A shorter pulse is never seen at offset 0x08. A threshold of 0 bypasses the filter.
- R5: The trigger type and polarity combine as follows:
  - Level type with polarity 1 fires while the level is high; with polarity 0 it fires while the level is low.
  - Single-edge type with polarity 1 fires on a rising edge; with polarity 0 it fires on a falling edge.
  - Both-edge type fires on every edge, whatever the polarity.
- R6: A pending bit can only be set while the pin is enabled and its trigger type is not none. Once set, it stays set until cleared.
- R7: Writing a value with bit 0 set to offset 0x14 clears that pin's pending bit. Writing 0 there leaves the bit unchanged. A level trigger that is still active sets the bit again on the following cycle.
- R8: `irq` is the OR of the pending bits whose interrupt enable is set. The status register shows pending bits whatever their interrupt enable.
- R9: `pad_oe[n]` is high exactly when pin n's direction bit is 1 and its float bit is 0. `pad_out[n]` follows bit 0 of the output value register. Neither output changes unless a bus write occurs.
- R10: After reset every register reads 0, except the float control bit, which reads 1. No pending bit is set, and `irq` and `pad_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | AW (12) | Byte address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pad_in | input | N (8) | Pad input levels, asynchronous |
| pad_out | output | N (8) | Pad output values |
| pad_oe | output | N (8) | Pad output enables |
| irq | output | 1 | Port interrupt |

## Verification
The assertions assume that `bus_wr` is a clean pulse and that every write is the only thing that can change configuration, output value or float state. They also assume that the pending-clear strobe is derived from a real bus write.

The stimulus keeps `bus_wr`, `bus_addr`, `bus_wdata` and `pad_in` stable across each rising edge by changing them only at the falling edge. Pad pulses that test the debounce filter are kept several cycles apart from the reads that observe them. Random bus traffic only targets pins inside the configured count and keeps thresholds small, so that filtered levels settle within the run.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int WIN_SHIFT   = 5;
  localparam int THR_W       = 8;
  localparam int STATUS_ADDR = 'h104;

  localparam logic [4:0] OFS_CFG = 5'h00;
  localparam logic [4:0] OFS_THR = 5'h04;
  localparam logic [4:0] OFS_LVL = 5'h08;
  localparam logic [4:0] OFS_FLT = 5'h0C;
  localparam logic [4:0] OFS_VAL = 5'h10;
  localparam logic [4:0] OFS_CLR = 5'h14;

  typedef enum logic [1:0] {
    TRIG_OFF   = 2'd0,
    TRIG_LEVEL = 2'd1,
    TRIG_EDGE  = 2'd2,
    TRIG_BOTH  = 2'd3
  } trig_e;

  typedef struct packed {
    logic  ie;
    logic  pol;
    trig_e trig;
    logic  dir;
    logic  en;
  } pin_cfg_t;

  // Input is {bit6, bits[4:0]} of the written byte.
  function automatic pin_cfg_t cfg_unpack(input logic [5:0] d);
    pin_cfg_t c;
    c.ie   = d[5];
    c.pol  = d[4];
    c.trig = trig_e'(d[3:2]);
    c.dir  = d[1];
    c.en   = d[0];
    return c;
  endfunction

  function automatic logic [7:0] cfg_pack(input pin_cfg_t c);
    return {1'b0, c.ie, 1'b0, c.pol, c.trig, c.dir, c.en};
  endfunction

  // Trigger decision from the current and previous filtered level.
  function automatic logic trig_hit(input trig_e t, input logic pol,
                                    input logic cur, input logic prev);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    case (t)
      TRIG_LEVEL: return (cur == pol);
      TRIG_EDGE:  return pol ? rise : fall;
      TRIG_BOTH:  return rise | fall;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= din;
      stage2_q <= stage1_q;
    end
  end

  assign dout = stage2_q;

endmodule

// File: rtl/gpio_irq_debounce.sv
module gpio_irq_debounce #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] thr,
  input  logic          din,
  output logic          dout
);

  logic          lvl_q;
  logic [TW-1:0] cnt_q;
  logic          bypass;

  assign bypass = (thr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (bypass) begin
      lvl_q <= din;
      cnt_q <= '0;
    end else if (din != lvl_q) begin
      if (cnt_q == thr) begin
        lvl_q <= din;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign dout = bypass ? din : lvl_q;

endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
  import gpio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cfg,
  input  logic             wr_thr,
  input  logic             wr_flt,
  input  logic             wr_val,
  input  logic             wr_clr,
  input  logic [7:0]       wdata,
  input  logic             sync_in,
  output logic [7:0]       cfg_rd,
  output logic [THR_W-1:0] thr_q,
  output logic             flt_q,
  output logic             val_q,
  output logic             lvl,
  output logic             pend_q,
  output logic             set_evt,
  output logic             clr_evt,
  output logic             armed,
  output logic             ie,
  output logic             oe
);

  pin_cfg_t cfg_q;
  logic     prev_q;

  gpio_irq_debounce #(.TW(THR_W)) u_dbn (
    .clk  (clk),
    .rst_n(rst_n),
    .thr  (thr_q),
    .din  (sync_in),
    .dout (lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      thr_q <= '0;
      flt_q <= 1'b1;
      val_q <= 1'b0;
    end else begin
      if (wr_cfg) cfg_q <= cfg_unpack({wdata[6], wdata[4:0]});
      if (wr_thr) thr_q <= wdata[THR_W-1:0];
      if (wr_flt) flt_q <= wdata[0];
      if (wr_val) val_q <= wdata[0];
    end
  end

  assign armed   = cfg_q.en && (cfg_q.trig != TRIG_OFF);
  assign set_evt = armed && trig_hit(cfg_q.trig, cfg_q.pol, lvl, prev_q);
  assign clr_evt = wr_clr && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl;
      pend_q <= set_evt | (pend_q & ~clr_evt);
    end
  end

  assign cfg_rd = cfg_pack(cfg_q);
  assign ie     = cfg_q.ie;
  assign oe     = cfg_q.dir & ~flt_q;

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic [N-1:0]  pad_in,
  output logic [N-1:0]  pad_out,
  output logic [N-1:0]  pad_oe,
  output logic          irq
);

  // N must stay at or below 8 so that the status address lies outside every pin window.
  localparam int IW = AW - WIN_SHIFT;
  localparam int PW = (N > 1) ? $clog2(N) : 1;
  localparam logic [IW-1:0] N_IDX = IW'(N);

  logic [IW-1:0] win_idx;
  logic [4:0]    win_ofs;
  logic [PW-1:0] win_sel;
  logic          in_pins;
  logic          is_stat;

  assign win_idx = bus_addr[AW-1:WIN_SHIFT];
  assign win_ofs = bus_addr[WIN_SHIFT-1:0];
  assign win_sel = bus_addr[WIN_SHIFT +: PW];
  assign in_pins = (win_idx < N_IDX);
  assign is_stat = (bus_addr == AW'(STATUS_ADDR));

  logic [N-1:0]            sync_v;
  logic [N-1:0][7:0]       cfg_a;
  logic [N-1:0][THR_W-1:0] thr_a;
  logic [N-1:0]            flt_v;
  logic [N-1:0]            lvl_v;
  logic [N-1:0]            pend_vec;
  logic [N-1:0]            set_vec;
  logic [N-1:0]            clr_vec;
  logic [N-1:0]            armed_vec;
  logic [N-1:0]            ie_vec;

  gpio_irq_sync #(.W(N)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pad_in),
    .dout (sync_v)
  );

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic pin_hit;
    assign pin_hit = bus_wr && (win_idx == IW'(g));

    gpio_irq_pin u_pin (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_cfg (pin_hit && (win_ofs == OFS_CFG)),
      .wr_thr (pin_hit && (win_ofs == OFS_THR)),
      .wr_flt (pin_hit && (win_ofs == OFS_FLT)),
      .wr_val (pin_hit && (win_ofs == OFS_VAL)),
      .wr_clr (pin_hit && (win_ofs == OFS_CLR)),
      .wdata  (bus_wdata),
      .sync_in(sync_v[g]),
      .cfg_rd (cfg_a[g]),
      .thr_q  (thr_a[g]),
      .flt_q  (flt_v[g]),
      .val_q  (pad_out[g]),
      .lvl    (lvl_v[g]),
      .pend_q (pend_vec[g]),
      .set_evt(set_vec[g]),
      .clr_evt(clr_vec[g]),
      .armed  (armed_vec[g]),
      .ie     (ie_vec[g]),
      .oe     (pad_oe[g])
    );
  end

  assign irq = |(pend_vec & ie_vec);

  always_comb begin
    bus_rdata = '0;
    if (is_stat) begin
      bus_rdata[N-1:0] = pend_vec;
    end else if (in_pins) begin
      case (win_ofs)
        OFS_CFG: bus_rdata = cfg_a[win_sel];
        OFS_THR: bus_rdata = thr_a[win_sel];
        OFS_LVL: bus_rdata[0] = lvl_v[win_sel];
        OFS_FLT: bus_rdata[0] = flt_v[win_sel];
        OFS_VAL: bus_rdata[0] = pad_out[win_sel];
        default: bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_wr,
  input logic [N-1:0] pend_vec,
  input logic [N-1:0] set_vec,
  input logic [N-1:0] clr_vec,
  input logic [N-1:0] pad_out,
  input logic [N-1:0] pad_oe,
  input logic         irq
);

  // R9: pad drive only moves after a bus write
  p_pad_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(pad_out) && $stable(pad_oe)));

  // R8: the port interrupt needs some pending bit behind it
  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|pend_vec));

  // R7: a clear with no simultaneous trigger empties the bit
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((pend_vec & $past(clr_vec & ~set_vec)) == '0));

  // R6: a pending bit appears only from a trigger event
  p_sticky_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((pend_vec & ~$past(pend_vec) & ~$past(set_vec)) == '0));

  // R6: a pending bit drops only after a clear
  p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((~pend_vec & $past(pend_vec) & ~$past(clr_vec)) == '0));

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.N(N)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_wr  (bus_wr),
  .pend_vec(pend_vec),
  .set_vec (set_vec),
  .clr_vec (clr_vec),
  .pad_out (pad_out),
  .pad_oe  (pad_oe),
  .irq     (irq)
);

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [N-1:0] pad_in = '0;
  logic [7:0]  rdata;
  logic [N-1:0] pad_out;
  logic [N-1:0] pad_oe;
  logic        irq;

  int nchk = 0;
  int nerr = 0;
  bit live = 0;

  always #4 clk = ~clk;

  gpio_irq_port u_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  // Behavioural reference, one integer per stored quantity.
  int m_cfg[N], m_thr[N], m_flt[N], m_val[N], m_pend[N];
  int m_s1[N], m_s2[N], m_held[N], m_cnt[N], m_prev[N];

  function automatic int m_level(int p);
    return (m_thr[p] == 0) ? m_s2[p] : m_held[p];
  endfunction

  function automatic int m_fires(int p);
    int kind, pol, cur, prv;
    kind = (m_cfg[p] >> 2) & 3;
    pol  = (m_cfg[p] >> 4) & 1;
    cur  = m_level(p);
    prv  = m_prev[p];
    if ((m_cfg[p] & 1) == 0) return 0;
    if (kind == 1) return (cur == pol);
    if (kind == 2) return pol ? (cur == 1 && prv == 0) : (cur == 0 && prv == 1);
    if (kind == 3) return (cur != prv);
    return 0;
  endfunction

  always @(posedge clk) begin
    for (int p = 0; p < N; p++) begin
      if (!rst_n) begin
        m_cfg[p] = 0; m_thr[p] = 0; m_flt[p] = 1; m_val[p] = 0; m_pend[p] = 0;
        m_s1[p] = 0; m_s2[p] = 0; m_held[p] = 0; m_cnt[p] = 0; m_prev[p] = 0;
      end else begin
        int base, lv, fire, clr;
        base = p * 32;
        lv   = m_level(p);
        fire = m_fires(p);
        clr  = (wr && addr == 12'(base + 'h14) && wdata[0]) ? 1 : 0;
        m_pend[p] = (fire != 0 || (m_pend[p] != 0 && clr == 0)) ? 1 : 0;
        if (m_thr[p] == 0) begin
          m_held[p] = m_s2[p]; m_cnt[p] = 0;
        end else if (m_s2[p] != m_held[p]) begin
          if (m_cnt[p] == m_thr[p]) begin m_held[p] = m_s2[p]; m_cnt[p] = 0; end
          else m_cnt[p]++;
        end else m_cnt[p] = 0;
        m_prev[p] = lv;
        m_s2[p] = m_s1[p];
        m_s1[p] = pad_in[p];
        if (wr && addr == 12'(base))         m_cfg[p] = wdata & 8'h5F;
        if (wr && addr == 12'(base + 'h04))  m_thr[p] = wdata;
        if (wr && addr == 12'(base + 'h0C))  m_flt[p] = wdata[0];
        if (wr && addr == 12'(base + 'h10))  m_val[p] = wdata[0];
      end
    end
  end

  function automatic int m_rdata(logic [11:0] a);
    int p, o, s;
    if (a == 12'h104) begin
      s = 0;
      for (int k = 0; k < N; k++) s |= (m_pend[k] << k);
      return s;
    end
    p = a / 32; o = a % 32;
    if (p >= N) return 0;
    case (o)
      'h00: return m_cfg[p];
      'h04: return m_thr[p];
      'h08: return m_level(p);
      'h0C: return m_flt[p];
      'h10: return m_val[p];
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison, sampled 3 ns after the rising edge.
  always @(posedge clk) begin
    #3;
    if (live && rst_n) begin
      int e_irq, e_oe, e_out;
      e_irq = 0; e_oe = 0; e_out = 0;
      for (int p = 0; p < N; p++) begin
        if (m_pend[p] != 0 && ((m_cfg[p] >> 6) & 1) != 0) e_irq = 1;
        e_oe  |= ((((m_cfg[p] >> 1) & 1) & (m_flt[p] ^ 1)) << p);
        e_out |= (m_val[p] << p);
      end
      check("R8 irq", int'(irq), e_irq);
      check("R9 pad_oe", int'(pad_oe), e_oe);
      check("R9 pad_out", int'(pad_out), e_out);
      check("R1 rdata", int'(rdata), m_rdata(addr));
    end
  end

  task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic read_val(input string tag, input logic [11:0] a, input int exp);
    @(negedge clk); addr = a;
    @(posedge clk); #3;
    check(tag, int'(rdata), exp);
  endtask

  task automatic read_bit(input string tag, input logic [11:0] a, input int b, input int exp);
    @(negedge clk); addr = a;
    @(posedge clk); #3;
    check(tag, int'(rdata[b]), exp);
  endtask

  task automatic set_pad(input int p, input logic v);
    @(negedge clk); pad_in[p] = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    live = 1;

    // R10 reset state
    read_val("R10 cfg pin0", 12'h000, 0);
    read_val("R10 float pin3", 12'h06C, 1);
    check("R10 pad_oe", int'(pad_oe), 0);
    check("R10 irq", int'(irq), 0);

    // R9 pad drive
    bus_write(12'h050, 8'h01);
    bus_write(12'h04C, 8'h00);
    bus_write(12'h040, 8'h03);
    idle(1);
    check("R9 oe pin2", int'(pad_oe[2]), 1);
    check("R9 out pin2", int'(pad_out[2]), 1);
    bus_write(12'h04C, 8'h01);
    idle(1);
    check("R9 float pin2", int'(pad_oe[2]), 0);

    // R2 config field readback
    bus_write(12'h020, 8'hFF);
    read_val("R2 cfg mask", 12'h020, 'h5F);
    bus_write(12'h020, 8'h00);

    // R1 windows and unmapped space
    bus_write(12'h064, 8'hA5);
    read_val("R1 thr pin3", 12'h064, 'hA5);
    read_val("R1 thr pin2", 12'h044, 0);
    read_val("R1 hole", 12'h018, 0);
    read_val("R1 beyond pins", 12'h1F0, 0);
    bus_write(12'h064, 8'h00);

    // R3 synchronized input, read-only
    set_pad(0, 1'b1);
    idle(4);
    read_val("R3 input high", 12'h008, 1);
    bus_write(12'h008, 8'h00);
    read_val("R3 write ignored", 12'h008, 1);

    // R4 debounce with threshold 3
    bus_write(12'h084, 8'h03);
    set_pad(4, 1'b1); set_pad(4, 1'b0);
    idle(8);
    read_val("R4 glitch rejected", 12'h088, 0);
    set_pad(4, 1'b1);
    idle(10);
    read_val("R4 level accepted", 12'h088, 1);

    // R5 level high on pin5
    bus_write(12'h0A0, 8'h55);
    set_pad(5, 1'b1);
    idle(6);
    read_bit("R5 level high", 12'h104, 5, 1);
    check("R8 irq from level", int'(irq), 1);

    // R5 rising edge on pin6
    bus_write(12'h0C0, 8'h59);
    set_pad(6, 1'b1); idle(6);
    read_bit("R5 rising", 12'h104, 6, 1);
    bus_write(12'h0D4, 8'h01);
    read_bit("R7 clear edge", 12'h104, 6, 0);
    set_pad(6, 1'b0); idle(6);
    read_bit("R5 rising ignores fall", 12'h104, 6, 0);

    // R5 falling edge
    bus_write(12'h0C0, 8'h49);
    set_pad(6, 1'b1); idle(6);
    read_bit("R5 falling ignores rise", 12'h104, 6, 0);
    set_pad(6, 1'b0); idle(6);
    read_bit("R5 falling", 12'h104, 6, 1);
    bus_write(12'h0D4, 8'h01);

    // R5 both edges, polarity set
    bus_write(12'h0C0, 8'h5D);
    set_pad(6, 1'b1); idle(6);
    read_bit("R5 both rise", 12'h104, 6, 1);
    bus_write(12'h0D4, 8'h01);
    read_bit("R5 both cleared", 12'h104, 6, 0);
    set_pad(6, 1'b0); idle(6);
    read_bit("R5 both fall", 12'h104, 6, 1);
    bus_write(12'h0D4, 8'h00);
    read_bit("R7 zero write keeps", 12'h104, 6, 1);

    // R8 interrupt enable gating
    bus_write(12'h0A0, 8'h00);
    set_pad(5, 1'b0);
    bus_write(12'h0B4, 8'h01);
    idle(3);
    check("R8 irq with ie", int'(irq), 1);
    bus_write(12'h0C0, 8'h1D);
    idle(2);
    check("R8 irq masked", int'(irq), 0);
    read_bit("R8 status unmasked", 12'h104, 6, 1);

    // R6 disabled pin never pends; R7 level re-arms
    bus_write(12'h0E0, 8'h44);
    idle(6);
    read_bit("R6 disabled", 12'h104, 7, 0);
    bus_write(12'h0E0, 8'h45);
    idle(3);
    read_bit("R6 enabled level low", 12'h104, 7, 1);
    bus_write(12'h0F4, 8'h01);
    read_bit("R7 level re-sets", 12'h104, 7, 1);
    set_pad(7, 1'b1); idle(5);
    bus_write(12'h0F4, 8'h01);
    read_bit("R7 cleared inactive", 12'h104, 7, 0);

    // Random traffic, compared against the model each cycle
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      wr = 1'b0;
      if ($urandom_range(0, 3) == 0) pad_in[$urandom_range(0, N-1)] ^= 1'b1;
      if ($urandom_range(0, 5) == 0) begin
        int p, k;
        p = $urandom_range(0, N-1);
        k = $urandom_range(0, 5);
        wr = 1'b1;
        addr = 12'(p * 32 + k * 4);
        wdata = 8'($urandom);
        if (k == 1) wdata = wdata & 8'h03;
      end else begin
        addr = ($urandom_range(0, 7) == 0) ? 12'h104 : 12'($urandom_range(0, 255));
      end
    end
    @(negedge clk); wr = 1'b0;
    idle(4);
    finish_run();
  end

endmodule